// File: doc/BRIEF.md
# Buffered PWM Channel with Left and Center Alignment

This block produces one pulse-width modulated output from an up/down counter. The counter advances only on a clock-enable tick, chosen from two tick inputs. The counter is built from `NBYTES` 8-bit stages. With the default of two stages it behaves as two 8-bit channels joined into one 16-bit counter. In left-aligned mode the counter ramps up and wraps. In center-aligned mode it climbs to the period value and descends back to zero, which gives a symmetric pulse. A polarity bit selects whether the active part of the pulse is high or low.

Software writes period and duty into shadow buffers through a small byte-wide register bus. The buffered values reach the active compare registers only at the end of a period, on a counter write, or at any time while the channel is disabled, so a running waveform never sees a half-updated setting. A sequencer with three states, `ST_OFF`, `ST_UP` and `ST_DOWN`, tracks the count direction:

- `ST_OFF` goes to `ST_UP` once the channel is enabled.
- Any state goes to `ST_OFF` when the enable is cleared.
- `ST_UP` goes to `ST_DOWN` when a center-mode tick finds the count at or above the period and above 1.
- `ST_DOWN` goes to `ST_UP` when a tick finds the count at 1 or 0, or when left-aligned mode is selected.
- A counter write forces `ST_UP` while the channel is enabled.

Top module: `pwm_channel`

## Requirements
- R1: While `rst_n` is low, all registers clear: control 0, buffers 0, active period and duty 0, counter 0. `pwm_o` then reads 1, because the duty is 0 and the polarity bit is 0.
- R2: The counter moves by at most one step, and only in a cycle where the selected tick is high and the channel is enabled. The enable is control bit 0. Control bit 3 selects the tick: 0 selects `tick_a`, 1 selects `tick_b`.
- R3: With control bit 1 at 0 (left-aligned), the counter runs 0, 1, … P-1 and then returns to 0, where P is the active period. A period of 0 or 1 holds it at 0.
- R4: With control bit 1 at 1 (center-aligned), the counter runs 0, 1, … P, P-1, … 1, 0 and repeats, giving 2·P ticks per period. The end of the period is the return to 0.
- R5: The output is active when the counter is below the active duty. Control bit 2 sets the active level: 1 means active high, 0 means active low, and the inactive level is the complement.
- R6: An active duty of 0 gives a constant inactive level. A nonzero active duty that is at least the active period gives a constant active level.
- R7: While the channel is enabled, the active period and duty copy their buffers only at the end of a period. A buffer written mid-period therefore has no effect until the next boundary. If a buffer write and a boundary fall in the same cycle, the old buffer value is loaded. While the channel is disabled, the active registers follow the buffers on every cycle.
- R8: A bus write of any data to address 5 or 6 clears the counter, sets the direction to up and loads both active registers from their buffers in that cycle. A tick in the same cycle is discarded.
- R9: With the enable at 0 the counter holds its value. After re-enabling, it resumes counting upward from the held value.
- R10: Reads are combinational and change nothing. `rdata` returns the whole register: address 0 gives control, 1 and 2 give the period buffer, 3 and 4 give the duty buffer, 5 and 6 give the counter, and 7 reads 0.
- R11: Bytes are written through lanes. Address 1 or 2 writes the period low or high byte, and address 3 or 4 writes the duty low or high byte. A write to the counter high byte (address 6) clears the whole 16-bit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | First clock-enable tick source |
| tick_b | input | 1 | Second clock-enable tick source |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 3 | Bus register address |
| wdata | input | 8 | Bus write byte |
| rdata | output | 8*NBYTES | Full-width read data of the addressed register |
| pwm_o | output | 1 | PWM output |

## Verification
Two functions can fall in the same cycle. A counter write can coincide with a selected tick, and a buffer write can land on the cycle in which the period ends. The bench provokes the first case by writing the counter while ticks arrive every cycle. It provokes the second by rewriting period and duty at many phases of a running waveform, so some writes fall on a wrap. In each case a behavioural model, applying the rule that a write beats a tick and a boundary loads the pre-write buffer, predicts the counter and the output, and these are compared with the design on every clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } cnt_state_e;

    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_PER_LO  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DUTY_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd5;

    typedef struct packed {
        logic tick_sel;
        logic pol_high;
        logic center;
        logic enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NBYTES = 2,
    localparam int CW = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic [CW-1:0]     per_buf,
    output logic [CW-1:0]     duty_buf,
    output logic              cnt_wr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && addr == A_CTRL) begin
            ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_buf  <= '0;
            duty_buf <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (addr == A_PER_LO + ADDR_W'(b)) begin
                    per_buf[BYTE_W*b +: BYTE_W] <= wdata;
                end
                if (addr == A_DUTY_LO + ADDR_W'(b)) begin
                    duty_buf[BYTE_W*b +: BYTE_W] <= wdata;
                end
            end
        end
    end

    always_comb begin
        cnt_wr = 1'b0;
        for (int b = 0; b < NBYTES; b++) begin
            if (wr_en && addr == A_CNT_LO + ADDR_W'(b)) begin
                cnt_wr = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          center,
    input  logic          tick,
    input  logic          cnt_wr,
    input  logic [CW-1:0] per_buf,
    input  logic [CW-1:0] duty_buf,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] per_act,
    output logic [CW-1:0] duty_act,
    output cnt_state_e    state_q
);

    localparam logic [CW:0]   ONE_X = {{CW{1'b0}}, 1'b1};
    localparam logic [CW-1:0] ONE   = {{(CW-1){1'b0}}, 1'b1};

    cnt_state_e    state_d;
    logic [CW-1:0] cnt_d;
    logic          load;
    logic [CW:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + ONE_X;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_act  <= '0;
            duty_act <= '0;
        end else if (load) begin
            per_act  <= per_buf;
            duty_act <= duty_buf;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        if (cnt_wr) begin
            cnt_d   = '0;
            load    = 1'b1;
            state_d = en ? ST_UP : ST_OFF;
        end else if (!en) begin
            state_d = ST_OFF;
            load    = 1'b1;
        end else begin
            unique case (state_q)
                ST_OFF, ST_UP: begin
                    state_d = ST_UP;
                    if (tick) begin
                        if (!center) begin
                            if (cnt_inc >= {1'b0, per_act}) begin
                                cnt_d = '0;
                                load  = 1'b1;
                            end else begin
                                cnt_d = cnt_inc[CW-1:0];
                            end
                        end else if (cnt_q >= per_act) begin
                            if (cnt_q <= ONE) begin
                                cnt_d = '0;
                                load  = 1'b1;
                            end else begin
                                cnt_d   = cnt_q - ONE;
                                state_d = ST_DOWN;
                            end
                        end else begin
                            cnt_d = cnt_inc[CW-1:0];
                        end
                    end
                end
                ST_DOWN: begin
                    if (!center) begin
                        state_d = ST_UP;
                        if (tick) begin
                            if (cnt_inc >= {1'b0, per_act}) begin
                                cnt_d = '0;
                                load  = 1'b1;
                            end else begin
                                cnt_d = cnt_inc[CW-1:0];
                            end
                        end
                    end else if (tick) begin
                        if (cnt_q <= ONE) begin
                            cnt_d   = '0;
                            load    = 1'b1;
                            state_d = ST_UP;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                default: begin
                    state_d = ST_OFF;
                end
            endcase
        end
    end

endmodule

// File: rtl/pwm_outgen.sv
module pwm_outgen #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt_q,
    input  logic [CW-1:0] per_act,
    input  logic [CW-1:0] duty_act,
    input  logic          pol_high,
    output logic          pwm_o
);

    logic active;

    always_comb begin
        active = (duty_act != '0) && ((duty_act >= per_act) || (cnt_q < duty_act));
        pwm_o  = active ? pol_high : ~pol_high;
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int NBYTES = 2,
    localparam int CW = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_a,
    input  logic              tick_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CW-1:0]     rdata,
    output logic              pwm_o
);

    ctrl_t         ctrl_q;
    logic [CW-1:0] per_buf;
    logic [CW-1:0] duty_buf;
    logic          cnt_wr;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] per_act;
    logic [CW-1:0] duty_act;
    cnt_state_e    state_q;
    logic          sel_tick;
    logic          en_w;
    logic          pol_w;

    assign sel_tick = ctrl_q.tick_sel ? tick_b : tick_a;
    assign en_w     = ctrl_q.enable;
    assign pol_w    = ctrl_q.pol_high;

    pwm_regs #(.NBYTES(NBYTES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .ctrl_q   (ctrl_q),
        .per_buf  (per_buf),
        .duty_buf (duty_buf),
        .cnt_wr   (cnt_wr)
    );

    pwm_counter #(.CW(CW)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_w),
        .center   (ctrl_q.center),
        .tick     (sel_tick),
        .cnt_wr   (cnt_wr),
        .per_buf  (per_buf),
        .duty_buf (duty_buf),
        .cnt_q    (cnt_q),
        .per_act  (per_act),
        .duty_act (duty_act),
        .state_q  (state_q)
    );

    pwm_outgen #(.CW(CW)) u_outgen (
        .cnt_q    (cnt_q),
        .per_act  (per_act),
        .duty_act (duty_act),
        .pol_high (pol_w),
        .pwm_o    (pwm_o)
    );

    always_comb begin
        case (addr)
            3'd0:       rdata = CW'(ctrl_q);
            3'd1, 3'd2: rdata = per_buf;
            3'd3, 3'd4: rdata = duty_buf;
            3'd5, 3'd6: rdata = cnt_q;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          sel_tick,
    input logic          cnt_wr,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] per_act,
    input logic [CW-1:0] duty_act,
    input logic          pol_high,
    input logic          pwm_o
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    a_r8_cnt_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == '0);

    a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(cnt_q));

    a_r2_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_tick && !cnt_wr) |=> $stable(cnt_q));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sel_tick && !cnt_wr) |=>
            (cnt_q == $past(cnt_q) + ONE || cnt_q == $past(cnt_q) - ONE || cnt_q == '0));

    a_r7_load_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(per_act) && $past(en)) |-> cnt_q == '0);

    a_r6_zero_duty_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act == '0) |-> pwm_o == ~pol_high);

endmodule

bind pwm_channel pwm_channel_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_w),
    .sel_tick (sel_tick),
    .cnt_wr   (cnt_wr),
    .cnt_q    (cnt_q),
    .per_act  (per_act),
    .duty_act (duty_act),
    .pol_high (pol_w),
    .pwm_o    (pwm_o)
);

// File: tb/test_pwm_channel.sv
module test_pwm_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_a = 1'b0;
    logic        tick_b = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd5;
    logic [7:0]  wdata = 8'd0;
    logic [15:0] rdata;
    logic        pwm_o;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    int    div_a = 1;
    int    div_b = 2;
    bit    done = 1'b0;
    string cur_req = "R1";

    logic [3:0]  m_ctrl;
    logic [15:0] m_pbuf, m_dbuf, m_pact, m_dact, m_cnt;
    bit          m_down;

    always #5 clk = ~clk;

    pwm_channel i_pwm_channel (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_a (tick_a),
        .tick_b (tick_b),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .pwm_o  (pwm_o)
    );

    always @(negedge clk) begin
        cyc++;
        tick_a <= (cyc % div_a) == 0;
        tick_b <= (cyc % div_b) == 0;
    end

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_pbuf = '0; m_dbuf = '0;
            m_pact = '0; m_dact = '0; m_cnt = '0; m_down = 0;
        end else begin
            bit tk;
            bit ld;
            tk = m_ctrl[3] ? tick_b : tick_a;
            ld = 0;
            if (wr_en && (addr == 3'd5 || addr == 3'd6)) begin
                m_cnt = 0; m_down = 0; ld = 1;
            end else if (!m_ctrl[0]) begin
                m_down = 0; ld = 1;
            end else if (tk) begin
                if (!m_ctrl[1]) begin
                    m_down = 0;
                    if (int'(m_cnt) + 1 >= int'(m_pact)) begin m_cnt = 0; ld = 1; end
                    else m_cnt = m_cnt + 1;
                end else if (!m_down) begin
                    if (m_cnt >= m_pact) begin
                        if (m_cnt <= 1) begin m_cnt = 0; ld = 1; end
                        else begin m_cnt = m_cnt - 1; m_down = 1; end
                    end else m_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt <= 1) begin m_cnt = 0; ld = 1; m_down = 0; end
                    else m_cnt = m_cnt - 1;
                end
            end else if (!m_ctrl[1]) begin
                m_down = 0;
            end
            if (ld) begin m_pact = m_pbuf; m_dact = m_dbuf; end
            if (wr_en) begin
                case (addr)
                    3'd0: m_ctrl = wdata[3:0];
                    3'd1: m_pbuf[7:0] = wdata;
                    3'd2: m_pbuf[15:8] = wdata;
                    3'd3: m_dbuf[7:0] = wdata;
                    3'd4: m_dbuf[15:8] = wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic exp_out();
        bit act;
        act = (m_dact != 0) && ((m_dact >= m_pact) || (m_cnt < m_dact));
        return act ? m_ctrl[2] : ~m_ctrl[2];
    endfunction

    function automatic logic [15:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {12'd0, m_ctrl};
            3'd1, 3'd2: return m_pbuf;
            3'd3, 3'd4: return m_dbuf;
            3'd5, 3'd6: return m_cnt;
            default: return 16'd0;
        endcase
    endfunction

    // compare on every clock, well after the edge
    always @(posedge clk) begin
        #3;
        if (!done) begin
            checks++;
            if (pwm_o !== exp_out()) begin
                fails++;
                $display("FAIL %s pwm_o actual %0b expected %0b (t=%0t)", cur_req, pwm_o, exp_out(), $time);
            end
            if (!wr_en) begin
                checks++;
                if (rdata !== exp_rd(addr)) begin
                    fails++;
                    $display("FAIL %s rdata@%0d actual %0h expected %0h (t=%0t)", cur_req, addr, rdata, exp_rd(addr), $time);
                end
            end
        end
    end

    task automatic bus(input logic w, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en <= w; addr <= a; wdata <= d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bus(1'b0, 3'd5, 8'h00);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n <= 1'b1;
        idle(2);

        // R3 / R5: left-aligned, active high
        cur_req = "R3";
        bus(1, 3'd1, 8'd5); bus(1, 3'd3, 8'd2); bus(1, 3'd0, 8'b0101);
        idle(25);

        // R7: buffer rewrites at several phases, some on a wrap
        cur_req = "R7";
        for (int k = 0; k < 6; k++) begin
            bus(1, 3'd1, 8'(5 + k % 3)); idle(k);
            bus(1, 3'd3, 8'(1 + k % 4)); idle(9);
        end

        // R8: counter write while ticks arrive every cycle
        cur_req = "R8";
        bus(1, 3'd5, 8'hA5); idle(3);
        bus(1, 3'd3, 8'd4); bus(1, 3'd5, 8'h00); idle(12);

        // R2: sparse ticks, then second tick source
        cur_req = "R2";
        div_a = 3; idle(30);
        bus(1, 3'd0, 8'b1101); idle(30);
        div_a = 1; bus(1, 3'd0, 8'b0101);

        // R4: center-aligned
        cur_req = "R4";
        bus(1, 3'd1, 8'd4); bus(1, 3'd3, 8'd1); bus(1, 3'd0, 8'b0111);
        bus(1, 3'd5, 8'h3C); idle(30);

        // R6 / R5: zero duty, oversized duty, active low
        cur_req = "R6";
        bus(1, 3'd3, 8'd0); idle(20);
        bus(1, 3'd3, 8'd9); idle(20);
        cur_req = "R5";
        bus(1, 3'd3, 8'd2); bus(1, 3'd0, 8'b0011); idle(24);

        // R9: hold while disabled, resume upward
        cur_req = "R9";
        bus(1, 3'd0, 8'b0010); idle(10);
        bus(1, 3'd1, 8'd6); idle(3);
        bus(1, 3'd0, 8'b0011); idle(30);

        // R10: reads of every address while running
        cur_req = "R10";
        for (int k = 0; k < 24; k++) bus(0, 3'(k % 8), 8'hFF);

        // R11: 16-bit period and duty, high-byte counter write
        cur_req = "R11";
        bus(1, 3'd0, 8'b0101);
        bus(1, 3'd2, 8'd1); bus(1, 3'd1, 8'h2C);
        bus(1, 3'd4, 8'd0); bus(1, 3'd3, 8'd150);
        bus(1, 3'd6, 8'h77); idle(320);
        bus(1, 3'd6, 8'h01); idle(8);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule